// File: doc/BRIEF.md
# Trap Redirect Target Generator

This block produces the program counter value a core jumps to when it takes a trap. The core pulses a request with three things: whether the trap is an interrupt or an exception, the cause number, and that interrupt's per-source vectored flag. The block then returns a one-cycle redirect strobe with the target address. It reads three address registers that are held elsewhere: the trap-vector register, whose two low bits select the handling mode; a vector-table base register; and a non-vectored interrupt entry register.

There are three handling modes. In single-entry mode every trap goes to one common handler. In vectored mode an interrupt lands in a 4-byte slot that holds a jump instruction. In table-driven mode a vectored interrupt does not jump to its slot. Instead the block issues a memory read for the table word, using a valid/ready request, and jumps to the handler address that the read returns. In table-driven mode, non-vectored interrupts may go to a separate entry register.

Top module: `trap_target_gen`

## Requirements
- R1: After a synchronous active-low reset, `redir_valid` and `rd_req_valid` are both low.
- R2: When `tvec_reg[1:0]` is 0 (single-entry) or 2 (reserved, treated the same way), every accepted trap redirects to `tvec_reg` with bits [1:0] cleared.
- R3: When `tvec_reg[1:0]` is 1 (vectored), an accepted interrupt with cause n redirects to the cleared base + 4*n.
- R4: In every mode, an exception redirects to `tvec_reg` with bits [1:0] cleared, and never to an offset slot.
- R5: When `tvec_reg[1:0]` is 3 (table-driven), an accepted interrupt with `irq_shv`=1 gives no immediate redirect. It raises `rd_req_valid` one cycle after the request, with `rd_req_addr` = (`tbl_base_reg` with bits [1:0] cleared) + 4*n.
- R6: While `rd_req_valid` is high and `rd_req_ready` is low, the request stays valid and `rd_req_addr` stays unchanged. The request drops in the cycle after the handshake.
- R7: A response accepted by `rd_rsp_valid` after the handshake raises `redir_valid` for exactly one cycle, in the next cycle. The target is `rd_rsp_data` with bits [1:0] cleared.
- R8: In table-driven mode, an interrupt with `irq_shv`=0 redirects to `nv_entry_reg` with bits [1:0] cleared when `nv_entry_reg[0]` is 1. Otherwise it redirects to the cleared `tvec_reg` base.
- R9: An interrupt request while `irq_glb_en` (status bit 3, mask 0x08) is low is ignored: no redirect and no table read follow it.
- R10: A trap request that arrives while a table read is outstanding is ignored. An `rd_rsp_valid` with no read outstanding is ignored.
- R11: A redirect that needs no table read appears on `redir_valid` in the cycle after the request is sampled, and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tvec_reg | input | XLEN | Trap-vector register; bits [1:0] select the mode |
| tbl_base_reg | input | XLEN | Handler-address table base |
| nv_entry_reg | input | XLEN | Non-vectored interrupt entry; bit 0 enables it |
| irq_glb_en | input | 1 | Global machine interrupt enable (status bit 3) |
| trap_req | input | 1 | One-cycle request to compute a trap target |
| trap_is_irq | input | 1 | 1 = interrupt, 0 = exception |
| trap_cause | input | CAUSE_W | Interrupt number / cause |
| irq_shv | input | 1 | Per-interrupt vectored flag |
| rd_req_valid | output | 1 | Table read request valid |
| rd_req_ready | input | 1 | Table read request accepted |
| rd_req_addr | output | XLEN | Table slot address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | XLEN | Handler address read from the table |
| redir_valid | output | 1 | One-cycle done strobe |
| redir_addr | output | XLEN | Redirect target |

## Verification
The mode decoder is tried with the same interrupt cause under each of the four values of the mode bits. This shows whether the slot offset is applied only in vectored mode and held back in the others. Causes 0, 5 and the largest value check that the offset is scaled by four and zero-extended. Each case is repeated with exceptions, which must always return the base address. Table-driven interrupts run with a stalled request handshake, with a trap request and a stray response arriving at the wrong times, and with the entry enable bit both set and clear. These cases separate the read path, the stall rule, the busy filter and the non-vectored fallback.

// File: rtl/trap_tgt_pkg.sv
// Shared types for the trap target generator.
// Assumes the mode field occupies the two low bits of the trap-vector register.
package trap_tgt_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        VM_SINGLE = 2'd0,
        VM_VECT   = 2'd1,
        VM_RSVD   = 2'd2,
        VM_TABLE  = 2'd3
    } vmode_e;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_REQ  = 2'd1,
        FS_WAIT = 2'd2
    } fstate_e;

endpackage

// File: rtl/trap_mode_dec.sv
// Combinational mode decode and target computation.
// Produces either an immediate target or a table-read address for one trap.
// Assumes XLEN > CAUSE_W + 2; all bases are forced to 4-byte alignment.
module trap_mode_dec
    import trap_tgt_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 10
) (
    input  logic [XLEN-1:0]    tvec_reg,
    input  logic [XLEN-1:0]    tbl_base_reg,
    input  logic [XLEN-1:0]    nv_entry_reg,
    input  logic               is_irq,
    input  logic [CAUSE_W-1:0] cause,
    input  logic               shv,
    output logic [XLEN-1:0]    direct_tgt,
    output logic               need_fetch,
    output logic [XLEN-1:0]    fetch_addr
);
    localparam int              PAD        = XLEN - CAUSE_W - 2;
    localparam logic [XLEN-1:0] ALIGN_MASK = ~{{(XLEN-2){1'b0}}, 2'b11};

    vmode_e          mode;
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] slot_off;

    // Split the mode field from the aligned base and scale the cause to a slot offset.
    always_comb begin
        mode     = vmode_e'(tvec_reg[MODE_W-1:0]);
        base     = tvec_reg & ALIGN_MASK;
        slot_off = {{PAD{1'b0}}, cause, 2'b00};
    end

    // Pick the immediate target, or request a table read, per mode and trap kind.
    always_comb begin
        direct_tgt = base;
        need_fetch = 1'b0;
        fetch_addr = (tbl_base_reg & ALIGN_MASK) + slot_off;
        unique case (mode)
            VM_VECT: begin
                if (is_irq) direct_tgt = base + slot_off;
            end
            VM_TABLE: begin
                if (is_irq && shv)               need_fetch = 1'b1;
                else if (is_irq && nv_entry_reg[0]) direct_tgt = nv_entry_reg & ALIGN_MASK;
            end
            default: direct_tgt = base;
        endcase
    end

endmodule

// File: rtl/trap_tbl_fetch.sv
// Handler-table read sequencer: issues one valid/ready read and waits for its data.
// Assumes the response never arrives in the same cycle as the request handshake.
module trap_tbl_fetch
    import trap_tgt_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [XLEN-1:0] start_addr,
    output logic            req_valid,
    input  logic            req_ready,
    output logic [XLEN-1:0] req_addr,
    input  logic            rsp_valid,
    output logic            done,
    output logic            busy
);
    fstate_e         state;
    logic [XLEN-1:0] addr_q;

    // Advance the read sequence and hold the slot address for the whole request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= FS_IDLE;
            addr_q <= '0;
        end else begin
            unique case (state)
                FS_IDLE: if (start) begin
                    state  <= FS_REQ;
                    addr_q <= start_addr;
                end
                FS_REQ:  if (req_ready) state <= FS_WAIT;
                FS_WAIT: if (rsp_valid) state <= FS_IDLE;
                default: state <= FS_IDLE;
            endcase
        end
    end

    // Drive the request and report completion as the data is accepted.
    always_comb begin
        req_valid = (state == FS_REQ);
        req_addr  = addr_q;
        done      = (state == FS_WAIT) && rsp_valid;
        busy      = (state != FS_IDLE);
    end

endmodule

// File: rtl/trap_target_gen.sv
// Top of the trap target generator.
// Accepts one trap request per idle cycle, filters interrupts on the global
// enable, and registers the redirect strobe and target.
module trap_target_gen #(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [XLEN-1:0]    tvec_reg,
    input  logic [XLEN-1:0]    tbl_base_reg,
    input  logic [XLEN-1:0]    nv_entry_reg,
    input  logic               irq_glb_en,
    input  logic               trap_req,
    input  logic               trap_is_irq,
    input  logic [CAUSE_W-1:0] trap_cause,
    input  logic               irq_shv,
    output logic               rd_req_valid,
    input  logic               rd_req_ready,
    output logic [XLEN-1:0]    rd_req_addr,
    input  logic               rd_rsp_valid,
    input  logic [XLEN-1:0]    rd_rsp_data,
    output logic               redir_valid,
    output logic [XLEN-1:0]    redir_addr
);
    localparam logic [XLEN-1:0] ALIGN_MASK = ~{{(XLEN-2){1'b0}}, 2'b11};

    logic [XLEN-1:0] direct_tgt;
    logic [XLEN-1:0] fetch_addr;
    logic            need_fetch;
    logic            fetch_busy;
    logic            fetch_done;
    logic            accept;

    trap_mode_dec #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_dec (
        .tvec_reg     (tvec_reg),
        .tbl_base_reg (tbl_base_reg),
        .nv_entry_reg (nv_entry_reg),
        .is_irq       (trap_is_irq),
        .cause        (trap_cause),
        .shv          (irq_shv),
        .direct_tgt   (direct_tgt),
        .need_fetch   (need_fetch),
        .fetch_addr   (fetch_addr)
    );

    // A request is taken only when idle, and an interrupt only when enabled.
    always_comb accept = trap_req && !fetch_busy && (!trap_is_irq || irq_glb_en);

    trap_tbl_fetch #(.XLEN(XLEN)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept && need_fetch),
        .start_addr (fetch_addr),
        .req_valid  (rd_req_valid),
        .req_ready  (rd_req_ready),
        .req_addr   (rd_req_addr),
        .rsp_valid  (rd_rsp_valid),
        .done       (fetch_done),
        .busy       (fetch_busy)
    );

    // Register the one-cycle redirect from either the immediate or the table path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_valid <= 1'b0;
            redir_addr  <= '0;
        end else if (fetch_done) begin
            redir_valid <= 1'b1;
            redir_addr  <= rd_rsp_data & ALIGN_MASK;
        end else if (accept && !need_fetch) begin
            redir_valid <= 1'b1;
            redir_addr  <= direct_tgt;
        end else begin
            redir_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/trap_target_chk.sv
// Property checker for trap_target_gen, attached by bind below.
// Observes ports plus the sequencer busy flag.
module trap_target_chk #(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic [XLEN-1:0]    tvec_reg,
    input logic               irq_glb_en,
    input logic               trap_req,
    input logic               trap_is_irq,
    input logic [CAUSE_W-1:0] trap_cause,
    input logic               rd_req_valid,
    input logic               rd_req_ready,
    input logic [XLEN-1:0]    rd_req_addr,
    input logic               redir_valid,
    input logic [XLEN-1:0]    redir_addr,
    input logic               fetch_busy
);
    localparam logic [XLEN-1:0] ALIGN_MASK = ~{{(XLEN-2){1'b0}}, 2'b11};
    localparam int              PAD        = XLEN - CAUSE_W - 2;

    // R4
    exc_to_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req && !trap_is_irq && !fetch_busy
        |=> redir_valid && (redir_addr == ($past(tvec_reg) & ALIGN_MASK)));

    // R3
    vect_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req && trap_is_irq && irq_glb_en && !fetch_busy && (tvec_reg[1:0] == 2'b01)
        |=> redir_valid && (redir_addr ==
            (($past(tvec_reg) & ALIGN_MASK) + {{PAD{1'b0}}, $past(trap_cause), 2'b00})));

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

    // R6
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid && rd_req_ready |=> !rd_req_valid);

    // R9
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req && trap_is_irq && !irq_glb_en && !fetch_busy
        |=> !redir_valid && !rd_req_valid);

    // R7
    tgt_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> (redir_addr[1:0] == 2'b00));

    // R5
    req_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> (rd_req_addr[1:0] == 2'b00));

endmodule

bind trap_target_gen trap_target_chk #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tvec_reg     (tvec_reg),
    .irq_glb_en   (irq_glb_en),
    .trap_req     (trap_req),
    .trap_is_irq  (trap_is_irq),
    .trap_cause   (trap_cause),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .redir_valid  (redir_valid),
    .redir_addr   (redir_addr),
    .fetch_busy   (fetch_busy)
);

// File: tb/tb_trap_target_gen.sv
// Directed bench for trap_target_gen: one task per scenario.
module tb_trap_target_gen;
    localparam int XLEN    = 32;
    localparam int CAUSE_W = 10;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [XLEN-1:0]    tvec_reg, tbl_base_reg, nv_entry_reg;
    logic               irq_glb_en, trap_req, trap_is_irq, irq_shv;
    logic [CAUSE_W-1:0] trap_cause;
    logic               rd_req_valid, rd_req_ready, rd_rsp_valid;
    logic [XLEN-1:0]    rd_req_addr, rd_rsp_data;
    logic               redir_valid;
    logic [XLEN-1:0]    redir_addr;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    trap_target_gen #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) dut (
        .clk(clk), .rst_n(rst_n), .tvec_reg(tvec_reg), .tbl_base_reg(tbl_base_reg),
        .nv_entry_reg(nv_entry_reg), .irq_glb_en(irq_glb_en), .trap_req(trap_req),
        .trap_is_irq(trap_is_irq), .trap_cause(trap_cause), .irq_shv(irq_shv),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .redir_valid(redir_valid), .redir_addr(redir_addr)
    );

    task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    // Present one trap request, sampled at the next edge, then withdraw it.
    task automatic fire(input logic irq, input logic [CAUSE_W-1:0] c, input logic shv);
        trap_req = 1'b1; trap_is_irq = irq; trap_cause = c; irq_shv = shv;
        step();
        trap_req = 1'b0;
    endtask

    // Expect an immediate one-cycle redirect to tgt.
    task automatic expect_redir(input string req, input logic [XLEN-1:0] tgt);
        check({req, " valid"}, XLEN'(redir_valid), 1);
        check({req, " addr"}, redir_addr, tgt);
        check({req, " no read"}, XLEN'(rd_req_valid), 0);
        step();
        check({req, " one cycle R11"}, XLEN'(redir_valid), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; step(); step();
        check("R1 redir_valid", XLEN'(redir_valid), 0);
        check("R1 rd_req_valid", XLEN'(rd_req_valid), 0);
        rst_n = 1'b1; step();
    endtask

    task automatic t_single();
        tvec_reg = 32'h0000_1000;
        fire(1'b1, 10'd5, 1'b0); expect_redir("R2 single irq", 32'h0000_1000);
        tvec_reg = 32'h0000_1002;
        fire(1'b1, 10'd5, 1'b1); expect_redir("R2 reserved irq", 32'h0000_1000);
    endtask

    task automatic t_vectored();
        tvec_reg = 32'h0000_1001;
        fire(1'b1, 10'd5, 1'b0);    expect_redir("R3 cause 5", 32'h0000_1014);
        fire(1'b1, 10'd0, 1'b0);    expect_redir("R3 cause 0", 32'h0000_1000);
        fire(1'b1, 10'd1023, 1'b0); expect_redir("R3 cause max", 32'h0000_1FFC);
        fire(1'b0, 10'd5, 1'b0);    expect_redir("R4 exc vectored", 32'h0000_1000);
    endtask

    task automatic t_exc_table();
        tvec_reg = 32'h0000_1003;
        fire(1'b0, 10'd7, 1'b1); expect_redir("R4 exc table", 32'h0000_1000);
    endtask

    task automatic t_table_fetch();
        tvec_reg = 32'h0000_1003; tbl_base_reg = 32'h0000_2002; rd_req_ready = 1'b0;
        fire(1'b1, 10'd7, 1'b1);
        check("R5 no immediate redirect", XLEN'(redir_valid), 0);
        check("R5 req valid", XLEN'(rd_req_valid), 1);
        check("R5 req addr", rd_req_addr, 32'h0000_201C);
        step(); step();
        check("R6 held valid", XLEN'(rd_req_valid), 1);
        check("R6 held addr", rd_req_addr, 32'h0000_201C);
        rd_req_ready = 1'b1; step(); rd_req_ready = 1'b0;
        check("R6 drop after handshake", XLEN'(rd_req_valid), 0);
        fire(1'b0, 10'd2, 1'b0);
        check("R10 busy request ignored", XLEN'(redir_valid), 0);
        step();
        check("R10 still no redirect", XLEN'(redir_valid), 0);
        rd_rsp_valid = 1'b1; rd_rsp_data = 32'h0000_4567; step(); rd_rsp_valid = 1'b0;
        check("R7 done valid", XLEN'(redir_valid), 1);
        check("R7 done addr", redir_addr, 32'h0000_4564);
        step();
        check("R7 one cycle", XLEN'(redir_valid), 0);
        rd_rsp_valid = 1'b1; rd_rsp_data = 32'h0000_8888; step(); rd_rsp_valid = 1'b0;
        check("R10 stray response", XLEN'(redir_valid), 0);
        check("R10 stray no read", XLEN'(rd_req_valid), 0);
    endtask

    task automatic t_table_nv();
        tvec_reg = 32'h0000_1003; nv_entry_reg = 32'h0000_3001;
        fire(1'b1, 10'd9, 1'b0); expect_redir("R8 nv enabled", 32'h0000_3000);
        nv_entry_reg = 32'h0000_3000;
        fire(1'b1, 10'd9, 1'b0); expect_redir("R8 nv disabled", 32'h0000_1000);
    endtask

    task automatic t_masked();
        irq_glb_en = 1'b0;
        tvec_reg = 32'h0000_1001;
        fire(1'b1, 10'd5, 1'b0);
        check("R9 vectored masked", XLEN'(redir_valid), 0);
        tvec_reg = 32'h0000_1003;
        fire(1'b1, 10'd7, 1'b1);
        check("R9 table masked redirect", XLEN'(redir_valid), 0);
        check("R9 table masked read", XLEN'(rd_req_valid), 0);
        fire(1'b0, 10'd3, 1'b0); expect_redir("R9 exc unmasked", 32'h0000_1000);
        irq_glb_en = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0; tvec_reg = '0; tbl_base_reg = '0; nv_entry_reg = '0;
        irq_glb_en = 1'b1; trap_req = 1'b0; trap_is_irq = 1'b0; trap_cause = '0;
        irq_shv = 1'b0; rd_req_ready = 1'b0; rd_rsp_valid = 1'b0; rd_rsp_data = '0;
        @(negedge clk);
        t_reset();
        t_single();
        t_vectored();
        t_exc_table();
        t_table_fetch();
        t_table_nv();
        t_masked();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(4 * 20000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule